// File: doc/BRIEF.md
# Hardware Cursor Overlay

The block places a small cursor image with per-pixel alpha over the pixel stream that leaves a display timing generator. Software sets a signed cursor position, the cursor size, the active screen size and an interlace flag. These settings are shadowed and become active together on a frame-done pulse. The block clips the cursor against all four screen edges. When the cursor hangs off the left or top edge, the first visible pixel is moved inward in the bitmap. When it hangs off the right or bottom edge, the visible span is cut short. In interlaced operation each field shows every other bitmap row, so the vertical position and the visible height are halved and the row stride is doubled.

The cursor image is held in an internal RAM of 2048 words, split into two banks. A load port streams ARGB pixels in raster order. Each pixel is stored with red and blue exchanged. The write address steps through 256-entry segments and then moves into the second bank.

For every pixel coordinate from the timing generator, the block either passes the background through or blends the cursor texel over it using the texel's alpha. The blended result appears three clocks after the coordinate.

Top module: `cursor_overlay`

## Requirements
- R1: A cursor size is accepted only when width ≤ 64, height ≤ 64, and width and height are not both above 32. An active setting that breaks this rule shows no cursor: every pixel passes the background through.
- R2: On each axis, a negative position p gives a bitmap offset of -p and a screen start of 0. The visible span is the size minus that offset, with a floor of 0.
- R3: On each axis, a non-negative position p with p + size above the screen extent gives a visible span of extent - p, with a floor of 0. The bitmap offset is 0.
- R4: With `interlace` set, the vertical screen start and the visible height are halved (rounding down) and the bitmap row stride is 2 × width. Otherwise the stride is the width.
- R5: When the visible width or height is 0, after halving where interlace applies, the cursor is disabled and every pixel passes the background through.
- R6: A loaded word `ld_argb` = {A[31:24], R[23:16], G[15:8], B[7:0]} is stored as {A, B, G, R}. The output colour taken from a fully opaque texel equals the R, G and B that were loaded.
- R7: `ld_start` sets the load address `ld_addr` to 0x0000 and writes nothing in that cycle. Each `ld_valid` write adds 1 to the address. If the low 8 bits then wrap to 0, a further 0xF00 is added. If (address AND 0x30FF) is then 0, the address becomes 0x8000. The Nth word loaded after `ld_start` is bitmap element N-1 in raster order.
- R8: Position, size, screen size and interlace take effect only on a clock where `frame_done` is high. Changes made at other times have no effect on the output.
- R9: A pixel outside the visible window [x_start, x_start + vis_w) × [y_start, y_start + vis_h) leaves as the background `bg_rgb` unchanged.
- R10: A pixel inside the window reads bitmap element ((y_off + row) × stride + x_off + col) mod 2048, where row and col are its distances from the window start. Each output channel is (a·c + (255 − a)·b + 255) >> 8, where a is the texel alpha, c the texel channel and b the background channel. Pixels use the format {R[23:16], G[15:8], B[7:0]}.
- R11: `pix_out` is registered and returns the result for the coordinate and background presented three clocks earlier. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | Frame-done pulse; loads the shadowed cursor settings |
| cur_x | input | CW | Signed cursor X position |
| cur_y | input | CW | Signed cursor Y position |
| cur_w | input | SW | Cursor width in pixels |
| cur_h | input | SW | Cursor height in pixels |
| scr_w | input | CW | Active screen width |
| scr_h | input | CW | Active screen height (lines per frame or field grid) |
| interlace | input | 1 | Interlaced operation |
| pix_x | input | CW | Current pixel column from timing generator |
| pix_y | input | CW | Current pixel line from timing generator |
| bg_rgb | input | 24 | Background pixel, R/G/B |
| ld_start | input | 1 | Restart image load at address 0x0000 |
| ld_valid | input | 1 | Load one ARGB cursor pixel |
| ld_argb | input | 32 | Cursor pixel to load, A/R/G/B |
| ld_addr | output | 16 | Address the next loaded pixel is written to |
| pix_out | output | 24 | Blended output pixel, R/G/B |

## Verification
Several properties are checked on every clock: the active cursor settings hold steady between frame-done pulses, any enabled setting has a non-zero visible area within the size limits, pixels outside the window leave the block unchanged, and the load address steps and restarts as specified. The exact clipped offsets, the halving in interlaced mode, the bitmap index, the red/blue exchange and the alpha arithmetic can only be seen through the bench's scenarios. Those scenarios compare the output pixel against an independent model of the image RAM and of the clip rules, at each edge and across random positions.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam logic [15:0] BANK0_BASE = 16'h0000;
  localparam logic [15:0] BANK1_BASE = 16'h8000;
  localparam logic [15:0] SEG_JUMP   = 16'h0F00;
  localparam logic [15:0] BANK_MASK  = 16'h30FF;

  // exchange red and blue: ARGB in, ABGR out
  function automatic logic [31:0] swap_red_blue(input logic [31:0] v);
    return {v[31:24], v[7:0], v[15:8], v[23:16]};
  endfunction

  // segmented load address step
  function automatic logic [15:0] step_addr(input logic [15:0] a);
    logic [15:0] n;
    n = a + 16'd1;
    if (n[7:0] == 8'd0) n = n + SEG_JUMP;
    if ((n & BANK_MASK) == 16'd0) n = BANK1_BASE;
    return n;
  endfunction

  // straight alpha mix of one 8-bit channel
  function automatic logic [7:0] mix_chan(input logic [7:0] a, input logic [7:0] fg,
                                          input logic [7:0] bg);
    return 8'((17'(a) * 17'(fg) + 17'(8'hFF - a) * 17'(bg) + 17'd255) >> 8);
  endfunction
endpackage

// File: rtl/cursor_loader.sv
module cursor_loader
  import cursor_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_start,
  input  logic          ld_valid,
  input  logic [31:0]   ld_argb,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [15:0]   ld_addr
);
  logic [15:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || ld_start) addr_q <= BANK0_BASE;
    else if (ld_valid)   addr_q <= step_addr(addr_q);
  end

  assign wr_en   = ld_valid && !ld_start && !rst;
  assign wr_addr = AW'({addr_q[15], addr_q[13:12], addr_q[7:0]});
  assign wr_data = swap_red_blue(ld_argb);
  assign ld_addr = addr_q;
endmodule

// File: rtl/cursor_ram.sv
module cursor_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cursor_clip.sv
module cursor_clip #(
  parameter int CW   = 12,
  parameter int SW   = 7,
  parameter int MAXD = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_done,
  input  logic signed [CW-1:0] cur_x,
  input  logic signed [CW-1:0] cur_y,
  input  logic [SW-1:0]        cur_w,
  input  logic [SW-1:0]        cur_h,
  input  logic [CW-1:0]        scr_w,
  input  logic [CW-1:0]        scr_h,
  input  logic                 interlace,
  output logic                 en,
  output logic [CW-1:0]        x_scr,
  output logic [CW-1:0]        y_scr,
  output logic [SW-1:0]        vis_w,
  output logic [SW-1:0]        vis_h,
  output logic [SW-1:0]        x_off,
  output logic [SW-1:0]        y_off,
  output logic [SW:0]          stride
);
  localparam int HALF = MAXD / 2;
  localparam int XW   = CW + 2;

  logic signed [CW-1:0] pos_in [2];
  logic [SW-1:0]        sz_in  [2];
  logic [CW-1:0]        lim_in [2];

  assign pos_in[0] = cur_x;  assign pos_in[1] = cur_y;
  assign sz_in[0]  = cur_w;  assign sz_in[1]  = cur_h;
  assign lim_in[0] = scr_w;  assign lim_in[1] = scr_h;

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    logic signed [XW-1:0] p, s, l;
    logic [SW-1:0]        off, vis;
    logic [CW-1:0]        scr;
    always_comb begin
      p = {{2{pos_in[ax][CW-1]}}, pos_in[ax]};
      s = signed'(XW'(sz_in[ax]));
      l = signed'(XW'(lim_in[ax]));
      if (p < 0) begin
        off = SW'(-p);
        scr = '0;
        vis = (-p >= s) ? '0 : SW'(s + p);
      end else if (p + s > l) begin
        off = '0;
        scr = pos_in[ax];
        vis = (l > p) ? SW'(l - p) : '0;
      end else begin
        off = '0;
        scr = pos_in[ax];
        vis = sz_in[ax];
      end
    end
  end

  logic          size_ok;
  logic [SW-1:0] vh_n;
  logic [CW-1:0] ys_n;

  always_comb begin
    size_ok = (cur_w <= SW'(MAXD)) && (cur_h <= SW'(MAXD)) &&
              !((cur_w > SW'(HALF)) && (cur_h > SW'(HALF)));
    vh_n = interlace ? (g_axis[1].vis >> 1) : g_axis[1].vis;
    ys_n = interlace ? (g_axis[1].scr >> 1) : g_axis[1].scr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; x_scr <= '0; y_scr <= '0; vis_w <= '0; vis_h <= '0;
      x_off <= '0; y_off <= '0; stride <= '0;
    end else if (frame_done) begin
      en     <= size_ok && (g_axis[0].vis != '0) && (vh_n != '0);
      x_scr  <= g_axis[0].scr;
      y_scr  <= ys_n;
      vis_w  <= g_axis[0].vis;
      vis_h  <= vh_n;
      x_off  <= g_axis[0].off;
      y_off  <= g_axis[1].off;
      stride <= interlace ? {cur_w, 1'b0} : {1'b0, cur_w};
    end
  end
endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
  import cursor_pkg::*;
(
  input  logic [31:0] texel_abgr,
  input  logic [23:0] bg_rgb,
  output logic [23:0] mix_rgb
);
  // channel 0 = blue, 1 = green, 2 = red in the RGB word;
  // the stored texel keeps red low and blue high
  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign mix_rgb[8*ch +: 8] = mix_chan(texel_abgr[31:24],
                                         texel_abgr[8*(2-ch) +: 8],
                                         bg_rgb[8*ch +: 8]);
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW   = 12,
  parameter int SW   = 7,
  parameter int MAXD = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_done,
  input  logic signed [CW-1:0] cur_x,
  input  logic signed [CW-1:0] cur_y,
  input  logic [SW-1:0]        cur_w,
  input  logic [SW-1:0]        cur_h,
  input  logic [CW-1:0]        scr_w,
  input  logic [CW-1:0]        scr_h,
  input  logic                 interlace,
  input  logic [CW-1:0]        pix_x,
  input  logic [CW-1:0]        pix_y,
  input  logic [23:0]          bg_rgb,
  input  logic                 ld_start,
  input  logic                 ld_valid,
  input  logic [31:0]          ld_argb,
  output logic [15:0]          ld_addr,
  output logic [23:0]          pix_out
);
  localparam int AW = 11;
  localparam int LW = 2 * SW + 2;

  logic          en_r;
  logic [CW-1:0] x_scr_r, y_scr_r;
  logic [SW-1:0] vis_w_r, vis_h_r, x_off_r, y_off_r;
  logic [SW:0]   stride_r;

  cursor_clip #(.CW(CW), .SW(SW), .MAXD(MAXD)) u_clip (
    .clk(clk), .rst(rst), .frame_done(frame_done),
    .cur_x(cur_x), .cur_y(cur_y), .cur_w(cur_w), .cur_h(cur_h),
    .scr_w(scr_w), .scr_h(scr_h), .interlace(interlace),
    .en(en_r), .x_scr(x_scr_r), .y_scr(y_scr_r),
    .vis_w(vis_w_r), .vis_h(vis_h_r), .x_off(x_off_r), .y_off(y_off_r),
    .stride(stride_r)
  );

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;

  cursor_loader #(.AW(AW)) u_load (
    .clk(clk), .rst(rst), .ld_start(ld_start), .ld_valid(ld_valid),
    .ld_argb(ld_argb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_addr(ld_addr)
  );

  // stage 1: window test and bitmap index
  logic [CW-1:0] dx, dy;
  logic          hit_c;
  logic [AW-1:0] idx_c;
  logic [SW:0]   rsum;

  always_comb begin
    dx    = pix_x - x_scr_r;
    dy    = pix_y - y_scr_r;
    hit_c = en_r &&
            (pix_x >= x_scr_r) && (dx < CW'(vis_w_r)) &&
            (pix_y >= y_scr_r) && (dy < CW'(vis_h_r));
    rsum  = (SW+1)'(y_off_r) + (SW+1)'(dy[SW-1:0]);
    idx_c = AW'(LW'(rsum) * LW'(stride_r) + LW'(x_off_r) + LW'(dx[SW-1:0]));
  end

  logic          hit1, hit2;
  logic [23:0]   bg1, bg2;
  logic [AW-1:0] raddr1;
  logic [31:0]   texel;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit1 <= 1'b0; bg1 <= '0; raddr1 <= '0;
      hit2 <= 1'b0; bg2 <= '0;
    end else begin
      hit1 <= hit_c; bg1 <= bg_rgb; raddr1 <= idx_c;
      hit2 <= hit1;  bg2 <= bg1;
    end
  end

  // stage 2: texel read
  cursor_ram #(.AW(AW), .DW(32)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr1), .rdata(texel)
  );

  // stage 3: blend and register
  logic [23:0] mixed;

  cursor_mixer u_mix (.texel_abgr(texel), .bg_rgb(bg2), .mix_rgb(mixed));

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= hit2 ? mixed : bg2;
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int CW   = 12,
  parameter int SW   = 7,
  parameter int MAXD = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_done,
  input logic          ld_start,
  input logic          ld_valid,
  input logic [15:0]   ld_addr,
  input logic [23:0]   pix_out,
  input logic          act_en,
  input logic [CW-1:0] act_x_scr,
  input logic [CW-1:0] act_y_scr,
  input logic [SW-1:0] act_vis_w,
  input logic [SW-1:0] act_vis_h,
  input logic          hit2,
  input logic [23:0]   bg2
);
  localparam int HALF = MAXD / 2;

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable({act_en, act_x_scr, act_y_scr, act_vis_w, act_vis_h}));

  assert_size_cap_R1: assert property (@(posedge clk) disable iff (rst)
    act_en |-> (act_vis_w <= SW'(MAXD)) && (act_vis_h <= SW'(MAXD)) &&
               !((act_vis_w > SW'(HALF)) && (act_vis_h > SW'(HALF))));

  assert_nonzero_area_R5: assert property (@(posedge clk) disable iff (rst)
    act_en |-> (act_vis_w != '0) && (act_vis_h != '0));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    !hit2 |=> pix_out == $past(bg2));

  assert_reset_out_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pix_out == 24'd0);

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !ld_start && ld_addr[7:0] != 8'hFF) |=> ld_addr == $past(ld_addr) + 16'd1);

  assert_addr_restart_R7: assert property (@(posedge clk) disable iff (rst)
    ld_start |=> ld_addr == 16'h0000);
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .SW(SW), .MAXD(MAXD)) u_chk (
  .clk(clk), .rst(rst), .frame_done(frame_done), .ld_start(ld_start),
  .ld_valid(ld_valid), .ld_addr(ld_addr), .pix_out(pix_out),
  .act_en(en_r), .act_x_scr(x_scr_r), .act_y_scr(y_scr_r),
  .act_vis_w(vis_w_r), .act_vis_h(vis_h_r), .hit2(hit2), .bg2(bg2)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int SW = 7;

  logic                 clk, rst, frame_done, interlace, ld_start, ld_valid;
  logic signed [CW-1:0] cur_x, cur_y;
  logic [SW-1:0]        cur_w, cur_h;
  logic [CW-1:0]        scr_w, scr_h, pix_x, pix_y;
  logic [23:0]          bg_rgb, pix_out;
  logic [31:0]          ld_argb;
  logic [15:0]          ld_addr;

  cursor_overlay #(.CW(CW), .SW(SW), .MAXD(64)) dut (
    .clk(clk), .rst(rst), .frame_done(frame_done), .cur_x(cur_x), .cur_y(cur_y),
    .cur_w(cur_w), .cur_h(cur_h), .scr_w(scr_w), .scr_h(scr_h),
    .interlace(interlace), .pix_x(pix_x), .pix_y(pix_y), .bg_rgb(bg_rgb),
    .ld_start(ld_start), .ld_valid(ld_valid), .ld_argb(ld_argb),
    .ld_addr(ld_addr), .pix_out(pix_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] image [2048];

  // model of the active cursor setting
  int m_en, m_xs, m_ys, m_vw, m_vh, m_xo, m_yo, m_st;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic clip1(input int p, input int s, input int l,
                       output int off, output int scr, output int vis);
    if (p < 0) begin
      off = -p; scr = 0; vis = (off >= s) ? 0 : s - off;
    end else if (p + s > l) begin
      off = 0; scr = p; vis = (l > p) ? l - p : 0;
    end else begin
      off = 0; scr = p; vis = s;
    end
  endtask

  task automatic model_cfg(input int x, input int y, input int w, input int h,
                           input int sw, input int sh, input int il);
    int ok;
    ok = (w <= 64 && h <= 64 && !(w > 32 && h > 32)) ? 1 : 0;
    clip1(x, w, sw, m_xo, m_xs, m_vw);
    clip1(y, h, sh, m_yo, m_ys, m_vh);
    if (il != 0) begin
      m_ys = m_ys / 2; m_vh = m_vh / 2; m_st = 2 * w;
    end else m_st = w;
    m_en = (ok != 0 && m_vw > 0 && m_vh > 0) ? 1 : 0;
  endtask

  function automatic logic [7:0] mix(input int a, input int f, input int b);
    return 8'((a * f + (255 - a) * b + 255) / 256);
  endfunction

  function automatic logic [23:0] exp_pix(input int px, input int py, input logic [23:0] bg);
    int idx;
    logic [31:0] c;
    if (m_en != 0 && px >= m_xs && px < m_xs + m_vw && py >= m_ys && py < m_ys + m_vh) begin
      idx = ((m_yo + (py - m_ys)) * m_st + m_xo + (px - m_xs)) & 2047;
      c = image[idx];
      return {mix(int'(c[31:24]), int'(c[23:16]), int'(bg[23:16])),
              mix(int'(c[31:24]), int'(c[15:8]),  int'(bg[15:8])),
              mix(int'(c[31:24]), int'(c[7:0]),   int'(bg[7:0]))};
    end
    return bg;
  endfunction

  task automatic drive_cfg(input int x, input int y, input int w, input int h,
                           input int sw, input int sh, input int il);
    cur_x = CW'(x); cur_y = CW'(y); cur_w = SW'(w); cur_h = SW'(h);
    scr_w = CW'(sw); scr_h = CW'(sh); interlace = il[0];
  endtask

  task automatic apply_cfg(input int x, input int y, input int w, input int h,
                           input int sw, input int sh, input int il);
    @(negedge clk);
    drive_cfg(x, y, w, h, sw, sh, il);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    model_cfg(x, y, w, h, sw, sh, il);
  endtask

  task automatic pix_check(input string req, input int px, input int py, input logic [23:0] bg);
    @(negedge clk);
    pix_x = CW'(px); pix_y = CW'(py); bg_rgb = bg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req, {8'h0, pix_out}, {8'h0, exp_pix(px, py, bg)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rst = 1'b1; frame_done = 1'b0; ld_start = 1'b0; ld_valid = 1'b0; ld_argb = '0;
    drive_cfg(0, 0, 0, 0, 0, 0, 0);
    pix_x = '0; pix_y = '0; bg_rgb = '0;
    model_cfg(0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset output", {8'h0, pix_out}, 32'h0);
    check("R7 reset address", {16'h0, ld_addr}, 32'h0);

    // full image load, checking the segmented address walk
    ld_start = 1'b1;
    @(negedge clk);
    ld_start = 1'b0;
    check("R7 start address", {16'h0, ld_addr}, 32'h0);
    ld_valid = 1'b1;
    for (int i = 0; i < 2048; i++) begin
      ld_argb = $urandom;
      image[i] = ld_argb;
      @(negedge clk);
      if (i + 1 == 1)    check("R7 first step", {16'h0, ld_addr}, 32'h0001);
      if (i + 1 == 256)  check("R7 segment jump", {16'h0, ld_addr}, 32'h1000);
      if (i + 1 == 1024) check("R7 second bank", {16'h0, ld_addr}, 32'h8000);
      if (i + 1 == 1280) check("R7 bank segment", {16'h0, ld_addr}, 32'h9000);
      if (i + 1 == 2048) check("R7 bank wrap", {16'h0, ld_addr}, 32'h8000);
    end
    ld_valid = 1'b0;

    // reload element 0 with an opaque known texel
    ld_start = 1'b1;
    @(negedge clk);
    ld_start = 1'b0; ld_valid = 1'b1; ld_argb = 32'hFF112233; image[0] = 32'hFF112233;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R7 restart then one write", {16'h0, ld_addr}, 32'h0001);

    apply_cfg(0, 0, 8, 8, 160, 120, 0);
    pix_check("R6 red/blue order", 0, 0, 24'hABCDEF);
    check("R6 opaque texel colour", {8'h0, pix_out}, 32'h00112233);
    pix_check("R10 inside window", 5, 3, 24'h405060);
    pix_check("R9 right of window", 8, 3, 24'h0F0F0F);

    // R8: change settings without frame_done
    @(negedge clk);
    drive_cfg(50, 40, 8, 8, 160, 120, 0);
    pix_check("R8 settings held", 0, 0, 24'h777777);
    pix_check("R8 new spot not active", 52, 42, 24'h777777);
    apply_cfg(50, 40, 8, 8, 160, 120, 0);
    pix_check("R8 old spot released", 0, 0, 24'h777777);
    pix_check("R8 new spot active", 52, 42, 24'h777777);

    // R2: left/top clip
    apply_cfg(-5, -3, 16, 16, 160, 120, 0);
    pix_check("R2 corner", 0, 0, 24'h102030);
    pix_check("R2 inside", 10, 12, 24'h102030);
    pix_check("R2 past width", 11, 0, 24'h102030);
    pix_check("R2 past height", 0, 13, 24'h102030);

    // R3: right/bottom clip
    apply_cfg(150, 115, 20, 10, 160, 120, 0);
    pix_check("R3 last pixel", 159, 119, 24'h00FF00);
    pix_check("R3 inside", 155, 117, 24'h00FF00);
    pix_check("R3 screen edge", 160, 117, 24'h00FF00);

    // R4: interlace
    apply_cfg(4, 10, 16, 20, 160, 120, 1);
    pix_check("R4 field start", 4, 5, 24'h123456);
    pix_check("R4 doubled stride", 10, 14, 24'h123456);
    pix_check("R4 halved height", 10, 15, 24'h123456);
    pix_check("R4 above field start", 10, 4, 24'h123456);

    // R5: zero visible area
    apply_cfg(160, 0, 8, 8, 160, 120, 0);
    pix_check("R5 x at screen edge", 159, 0, 24'hAAAAAA);
    apply_cfg(-16, 2, 16, 8, 160, 120, 0);
    pix_check("R5 fully left", 0, 3, 24'hAAAAAA);
    apply_cfg(2, 2, 8, 1, 160, 120, 1);
    pix_check("R5 interlace single line", 3, 1, 24'hAAAAAA);

    // R1: size limits
    apply_cfg(0, 0, 40, 40, 160, 120, 0);
    pix_check("R1 both above half", 1, 1, 24'h334455);
    apply_cfg(0, 0, 65, 8, 160, 120, 0);
    pix_check("R1 width above max", 1, 1, 24'h334455);
    apply_cfg(0, 0, 64, 32, 160, 120, 0);
    pix_check("R1 wide limit accepted", 63, 31, 24'h334455);
    apply_cfg(0, 0, 32, 64, 160, 120, 0);
    pix_check("R1 tall limit accepted", 31, 63, 24'h334455);

    // random settings and pixels
    for (int n = 0; n < 60; n++) begin
      int sw, sh, w, h, x, y, il;
      sw = 100 + int'($urandom % 100);
      sh = 80 + int'($urandom % 100);
      w  = 1 + int'($urandom % 64);
      h  = (w > 32) ? 1 + int'($urandom % 32) : 1 + int'($urandom % 64);
      x  = int'($urandom % (sw + 80)) - 40;
      y  = int'($urandom % (sh + 80)) - 40;
      il = int'($urandom % 2);
      apply_cfg(x, y, w, h, sw, sh, il);
      for (int k = 0; k < 8; k++) begin
        int px, py;
        px = m_xs + int'($urandom % (m_vw + 6)) - 3;
        py = m_ys + int'($urandom % (m_vh + 6)) - 3;
        if (px < 0) px = 0;
        if (py < 0) py = 0;
        pix_check("R10/R9 random", px, py, 24'($urandom));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule